// File: doc/BRIEF.md
# Adaptive Leave-Window-Out Threshold Detector

This block receives a vector of Q signed fixed-point statistics, one per sensor site or trace sample. It decides whether any entry stands out, using a threshold that it derives from that same vector. For every index k it sets aside a window of entries centred on k. It then takes the magnitudes that remain and forms a candidate threshold: their mean plus a configurable multiple (delta) of their standard deviation. The smallest candidate over all k becomes the threshold.

Because each candidate leaves its own neighbourhood out, one or a few strongly affected entries cannot raise the threshold that judges them. The block reports three results: a flag that is set when the largest magnitude is above the threshold, the threshold itself, and the index of the largest magnitude.

Samples arrive one per accepted cycle, in Q.8 format (8 fractional bits). Delta is an unsigned Q.8 multiplier, typically between 3.0 and 6.0. The window is given as a half-width h, which excludes 2h+1 entries. Each leave-out mean and variance comes from running totals minus a sliding window sum. The square root is computed bit-serially.

Top module: `leaveout_thresh_det`

## Requirements
- R1: After reset, in_ready is 1, and result_valid, infected, threshold and peak_idx are all 0.
- R2: A sample is taken on each clock edge where in_valid and in_ready are both 1. After the Q-th sample is taken, in_ready stays 0 until the result is issued. Any in_valid presented while in_ready is 0 has no effect on any later result.
- R3: Each sample is a two's complement value whose magnitude is used. The most negative code, 16'h8000, has magnitude 32768.
- R4: cfg_delta and cfg_half are captured together with the first sample of a vector. Changes to them later in the same vector have no effect on that vector's result.
- R5: For each k, the excluded indices run from max(0,k-h) to min(Q-1,k+h), and n is the number of entries kept. The candidate is built from these values:
  - mean = floor(S/n) and e2 = floor(SS/n), where S and SS are the sums of the kept magnitudes and of their squares.
  - sigma = floor(sqrt(e2 - mean*mean)).
  - candidate = mean + floor(delta*sigma/256).
- R6: threshold is the minimum candidate over all k. A k with n = 0 yields no candidate. If no k yields a candidate, threshold is 2^TH_W-1, all ones.
- R7: infected is 1 exactly when the largest magnitude in the vector is strictly greater than threshold.
- R8: peak_idx is the lowest index that holds the largest magnitude.
- R9: result_valid is a single-cycle pulse, raised in the same cycle that in_ready returns to 1. infected, threshold and peak_idx change only in a cycle with result_valid and hold their value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_sample | input | DATA_W | Signed Q.8 statistic |
| in_ready | output | 1 | Block is accepting samples |
| cfg_delta | input | DELTA_W | Unsigned Q.8 deviation multiplier |
| cfg_half | input | HALF_W | Half-width h of the excluded window |
| result_valid | output | 1 | One-cycle result strobe |
| infected | output | 1 | Largest magnitude exceeds threshold |
| threshold | output | TH_W | Adaptive threshold, Q.8 |
| peak_idx | output | IDX_W | Index of the largest magnitude |

## Verification
Faults in the internal state show up at the ports in different ways:
- A stale or wrongly slid window sum shifts every later candidate, so the threshold differs from the bit-exact model when the first result arrives, about one hundred cycles per index after the last sample.
- An off-by-one in window clipping appears only in vectors whose spike lies near an end of the vector.
- A corrupted running maximum shows up at once in peak_idx.
- A sample leaking in while the block is busy stays hidden until the next vector, so that vector's result is compared as well.

// File: rtl/leaveout_pkg.sv
package leaveout_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_PRIME,
        ST_KSTART,
        ST_DIV_SUM,
        ST_DIV_SQ,
        ST_ROOT,
        ST_NEXT,
        ST_FINISH
    } phase_e;

endpackage

// File: rtl/leaveout_div.sv
module leaveout_div #(
    parameter int NUM_W = 38,
    parameter int DEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] den;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] acc;
    } div_s;

    div_s d, q;
    logic [DEN_W:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.acc[NUM_W-1]};
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(NUM_W);
            d.den  = den;
            d.rem  = '0;
            d.acc  = num;
        end else if (q.busy) begin
            if (trial >= {1'b0, q.den}) begin
                d.rem = DEN_W'(trial - {1'b0, q.den});
                d.acc = {q.acc[NUM_W-2:0], 1'b1};
            end else begin
                d.rem = trial[DEN_W-1:0];
                d.acc = {q.acc[NUM_W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign quo  = q.acc;
endmodule

// File: rtl/leaveout_isqrt.sv
module leaveout_isqrt #(
    parameter int RAD_W = 32,
    parameter int RT_W  = RAD_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RAD_W-1:0] rad,
    output logic             done,
    output logic [RT_W-1:0]  root
);
    localparam int CNT_W = $clog2(RT_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [RAD_W-1:0] rad;
        logic [RT_W+1:0]  rem;
        logic [RT_W-1:0]  root;
    } sq_s;

    sq_s d, q;
    logic [RT_W+3:0] r2;
    logic [RT_W+3:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        r2     = {q.rem, q.rad[RAD_W-1 -: 2]};
        trial  = {2'b00, q.root, 2'b01};
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(RT_W);
            d.rad  = rad;
            d.rem  = '0;
            d.root = '0;
        end else if (q.busy) begin
            if (r2 >= trial) begin
                d.rem  = (RT_W + 2)'(r2 - trial);
                d.root = {q.root[RT_W-2:0], 1'b1};
            end else begin
                d.rem  = r2[RT_W+1:0];
                d.root = {q.root[RT_W-2:0], 1'b0};
            end
            d.rad = q.rad << 2;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign root = q.root;
endmodule

// File: rtl/leaveout_thresh_det.sv
module leaveout_thresh_det
    import leaveout_pkg::*;
#(
    parameter int Q       = 60,
    parameter int DATA_W  = 16,
    parameter int FRAC    = 8,
    parameter int DELTA_W = 12,
    parameter int HALF_W  = 11,
    parameter int IDX_W   = $clog2(Q),
    parameter int TH_W    = DELTA_W + DATA_W - FRAC + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_sample,
    output logic               in_ready,
    input  logic [DELTA_W-1:0] cfg_delta,
    input  logic [HALF_W-1:0]  cfg_half,
    output logic               result_valid,
    output logic               infected,
    output logic [TH_W-1:0]    threshold,
    output logic [IDX_W-1:0]   peak_idx
);
    localparam int MAG_W  = DATA_W;
    localparam int CNT_W  = $clog2(Q + 1);
    localparam int SUM_W  = MAG_W + CNT_W;
    localparam int SQ_W   = 2 * MAG_W;
    localparam int SSUM_W = SQ_W + CNT_W;
    localparam int PROD_W = DELTA_W + MAG_W;

    typedef struct packed {
        phase_e             st;
        logic [CNT_W-1:0]   idx;
        logic [IDX_W-1:0]   k;
        logic [DELTA_W-1:0] delta;
        logic [HALF_W-1:0]  half;
        logic [SUM_W-1:0]   tot_s;
        logic [SSUM_W-1:0]  tot_ss;
        logic [SUM_W-1:0]   win_s;
        logic [SSUM_W-1:0]  win_ss;
        logic [MAG_W-1:0]   peak_v;
        logic [IDX_W-1:0]   peak_i;
        logic [MAG_W-1:0]   mean;
        logic [TH_W-1:0]    thr;
        logic               res_v;
        logic               res_inf;
        logic [TH_W-1:0]    res_thr;
        logic [IDX_W-1:0]   res_idx;
    } core_s;

    core_s d, q;
    logic [MAG_W-1:0] mag_q [Q];

    logic [MAG_W-1:0]  mag_in;
    logic [SQ_W-1:0]   sq_in;
    logic [MAG_W-1:0]  rd_a, rd_b;
    logic [SQ_W-1:0]   sq_a, sq_b;
    logic              take;
    int                ki, hh, lo_i, hi_i, keep_i, add_i, drop_i;

    logic              div_start, div_done;
    logic [SSUM_W-1:0] div_num, div_quo;
    logic [CNT_W-1:0]  div_den;
    logic              sq_start, sq_done;
    logic [SQ_W-1:0]   sq_rad, m2;
    logic [MAG_W-1:0]  sq_root;
    logic [TH_W-1:0]   cand;

    leaveout_div #(.NUM_W(SSUM_W), .DEN_W(CNT_W)) div_i (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
        .den(div_den), .done(div_done), .quo(div_quo)
    );

    leaveout_isqrt #(.RAD_W(SQ_W), .RT_W(MAG_W)) sqrt_i (
        .clk(clk), .rst_n(rst_n), .start(sq_start), .rad(sq_rad),
        .done(sq_done), .root(sq_root)
    );

    assign take     = in_valid && (q.st == ST_LOAD);
    assign mag_in   = in_sample[DATA_W-1] ? (~in_sample + 1'b1) : in_sample;
    assign sq_in    = SQ_W'(mag_in) * SQ_W'(mag_in);
    assign m2       = SQ_W'(q.mean) * SQ_W'(q.mean);
    assign cand     = TH_W'(q.mean)
                    + TH_W'((PROD_W'(q.delta) * PROD_W'(sq_root)) >> FRAC);

    always_comb begin
        d         = q;
        d.res_v   = 1'b0;
        div_start = 1'b0;
        div_num   = '0;
        sq_start  = 1'b0;
        sq_rad    = '0;
        ki        = int'(q.k);
        hh        = int'(q.half);
        lo_i      = (ki - hh < 0) ? 0 : ki - hh;
        hi_i      = (ki + hh > Q - 1) ? Q - 1 : ki + hh;
        keep_i    = Q - (hi_i - lo_i + 1);
        div_den   = CNT_W'(keep_i);
        add_i     = ki + 1 + hh;
        drop_i    = ki - hh;
        rd_a      = (q.st == ST_PRIME) ? mag_q[IDX_W'(q.idx)] : mag_q[IDX_W'(add_i)];
        rd_b      = mag_q[IDX_W'(drop_i)];
        sq_a      = SQ_W'(rd_a) * SQ_W'(rd_a);
        sq_b      = SQ_W'(rd_b) * SQ_W'(rd_b);

        case (q.st)
            ST_LOAD: begin
                if (in_valid) begin
                    if (q.idx == '0) begin
                        d.delta  = cfg_delta;
                        d.half   = cfg_half;
                        d.tot_s  = SUM_W'(mag_in);
                        d.tot_ss = SSUM_W'(sq_in);
                        d.peak_v = mag_in;
                        d.peak_i = '0;
                        d.thr    = '1;
                    end else begin
                        d.tot_s  = q.tot_s + SUM_W'(mag_in);
                        d.tot_ss = q.tot_ss + SSUM_W'(sq_in);
                        if (mag_in > q.peak_v) begin
                            d.peak_v = mag_in;
                            d.peak_i = IDX_W'(q.idx);
                        end
                    end
                    if (q.idx == CNT_W'(Q - 1)) begin
                        d.st     = ST_PRIME;
                        d.idx    = '0;
                        d.win_s  = '0;
                        d.win_ss = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_PRIME: begin
                if ((int'(q.idx) < Q) && (int'(q.idx) <= int'(q.half))) begin
                    d.win_s  = q.win_s + SUM_W'(rd_a);
                    d.win_ss = q.win_ss + SSUM_W'(sq_a);
                    d.idx    = q.idx + 1'b1;
                end else begin
                    d.st = ST_KSTART;
                    d.k  = '0;
                end
            end
            ST_KSTART: begin
                if (keep_i == 0) begin
                    d.st = ST_NEXT;
                end else begin
                    div_start = 1'b1;
                    div_num   = SSUM_W'(q.tot_s - q.win_s);
                    d.st      = ST_DIV_SUM;
                end
            end
            ST_DIV_SUM: begin
                if (div_done) begin
                    d.mean    = div_quo[MAG_W-1:0];
                    div_start = 1'b1;
                    div_num   = q.tot_ss - q.win_ss;
                    d.st      = ST_DIV_SQ;
                end
            end
            ST_DIV_SQ: begin
                if (div_done) begin
                    sq_start = 1'b1;
                    sq_rad   = (div_quo[SQ_W-1:0] >= m2) ? div_quo[SQ_W-1:0] - m2 : '0;
                    d.st     = ST_ROOT;
                end
            end
            ST_ROOT: begin
                if (sq_done) begin
                    if (cand < q.thr) d.thr = cand;
                    d.st = ST_NEXT;
                end
            end
            ST_NEXT: begin
                if (ki == Q - 1) begin
                    d.st = ST_FINISH;
                end else begin
                    if (add_i < Q) begin
                        d.win_s  = d.win_s + SUM_W'(rd_a);
                        d.win_ss = d.win_ss + SSUM_W'(sq_a);
                    end
                    if (drop_i >= 0) begin
                        d.win_s  = d.win_s - SUM_W'(rd_b);
                        d.win_ss = d.win_ss - SSUM_W'(sq_b);
                    end
                    d.k  = q.k + 1'b1;
                    d.st = ST_KSTART;
                end
            end
            ST_FINISH: begin
                d.res_v   = 1'b1;
                d.res_thr = q.thr;
                d.res_inf = TH_W'(q.peak_v) > q.thr;
                d.res_idx = q.peak_i;
                d.idx     = '0;
                d.st      = ST_LOAD;
            end
            default: d.st = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (take) mag_q[IDX_W'(q.idx)] <= mag_in;
    end

    assign in_ready     = (q.st == ST_LOAD);
    assign result_valid = q.res_v;
    assign infected     = q.res_inf;
    assign threshold    = q.res_thr;
    assign peak_idx     = q.res_idx;
endmodule

// File: rtl/leaveout_thresh_det_chk.sv
module leaveout_thresh_det_chk #(
    parameter int Q     = 60,
    parameter int IDX_W = 6,
    parameter int TH_W  = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             result_valid,
    input logic             infected,
    input logic [TH_W-1:0]  threshold,
    input logic [IDX_W-1:0] peak_idx
);
    localparam int CW = $clog2(Q + 1);
    logic [CW-1:0] taken;

    always_ff @(posedge clk) begin
        if (!rst_n)                          taken <= '0;
        else if (in_valid && in_ready)       taken <= (taken == CW'(Q - 1)) ? '0 : taken + 1'b1;
    end

    a_r2_busy_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && taken == CW'(Q - 1)) |=> !in_ready);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r9_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> in_ready);

    a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(threshold) && $stable(infected) && $stable(peak_idx)));

    a_r6_saturated_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && threshold == {TH_W{1'b1}}) |-> !infected);

    a_r8_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (int'(peak_idx) < Q));
endmodule

bind leaveout_thresh_det leaveout_thresh_det_chk #(
    .Q(Q), .IDX_W(IDX_W), .TH_W(TH_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .result_valid(result_valid), .infected(infected),
    .threshold(threshold), .peak_idx(peak_idx)
);

// File: tb/leaveout_thresh_det_tb_top.sv
module leaveout_thresh_det_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q       = 60;
    localparam int DATA_W  = 16;
    localparam int DELTA_W = 12;
    localparam int HALF_W  = 11;
    localparam int IDX_W   = 6;
    localparam int TH_W    = 21;
    localparam int WD_LIMIT = 190000;

    typedef struct packed {
        int pat; int a; int b; int c; int delta; int half; int exp_inf; int exp_idx;
    } case_t;

    localparam int NCASE = 8;
    localparam case_t CASES [NCASE] = '{
        '{0,   256,      0,  0, 1024,  0, 0,  0},
        '{1,   256,   2560, 17, 1024,  0, 1, 17},
        '{1,  -300,  -3000,  0, 1536,  5, 1,  0},
        '{2,   500,      0,  0, 1024,  0, 0, -1},
        '{3,   500,  20000, 59, 1024,  2, 1, 59},
        '{1,   100, -32768, 30,  768,  1, 1, 30},
        '{3,  2000,   2600, 10, 1536,  0, 0, 10},
        '{2,  1200,      0,  0,  900,  7, -1, -1}
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic [DATA_W-1:0]  in_sample;
    logic               in_ready;
    logic [DELTA_W-1:0] cfg_delta;
    logic [HALF_W-1:0]  cfg_half;
    logic               result_valid;
    logic               infected;
    logic [TH_W-1:0]    threshold;
    logic [IDX_W-1:0]   peak_idx;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic signed [15:0] vec [Q];
    longint exp_thr, exp_inf, exp_idx;

    leaveout_thresh_det #(.Q(Q), .DATA_W(DATA_W), .DELTA_W(DELTA_W), .HALF_W(HALF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_ready(in_ready), .cfg_delta(cfg_delta), .cfg_half(cfg_half),
        .result_valid(result_valid), .infected(infected),
        .threshold(threshold), .peak_idx(peak_idx)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            n_fail = n_fail + 1;
            n_chk  = n_chk + 1;
            $display("FAIL R9 watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic signed [15:0] gen(int pat, int a, int b, int c, int i);
        int v;
        case (pat)
            0:       v = a;
            1:       v = (i == c) ? b : a;
            2:       v = ((i * 37 + 21) % (2 * a + 1)) - a;
            default: v = (i == c) ? b : ((i * 37 + 21) % (2 * a + 1)) - a;
        endcase
        return 16'(v);
    endfunction

    function automatic longint isq(longint v);
        longint r = 0;
        for (int b = 15; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= v) r = t;
        end
        return r;
    endfunction

    task automatic model(input int delta, input int half);
        longint m [Q];
        longint s = 0, ss = 0, best;
        exp_thr = (longint'(1) << TH_W) - 1;
        exp_idx = 0;
        for (int i = 0; i < Q; i++) begin
            m[i] = (vec[i] < 0) ? -longint'(vec[i]) : longint'(vec[i]);
            s += m[i];
            ss += m[i] * m[i];
        end
        best = m[0];
        for (int i = 1; i < Q; i++) if (m[i] > best) begin best = m[i]; exp_idx = i; end
        for (int k = 0; k < Q; k++) begin
            int lo = (k - half < 0) ? 0 : k - half;
            int hi = (k + half > Q - 1) ? Q - 1 : k + half;
            int n  = Q - (hi - lo + 1);
            longint ws = 0, wss = 0, mean, e2, vr, cnd;
            if (n == 0) continue;
            for (int j = lo; j <= hi; j++) begin ws += m[j]; wss += m[j] * m[j]; end
            mean = (s - ws) / n;
            e2   = (ss - wss) / n;
            vr   = e2 - mean * mean;
            if (vr < 0) vr = 0;
            cnd  = mean + ((longint'(delta) * isq(vr)) >> 8);
            if (cnd < exp_thr) exp_thr = cnd;
        end
        exp_inf = (best > exp_thr) ? 1 : 0;
    endtask

    task automatic run_vec(input int pat, input int a, input int b, input int c,
                           input int delta, input int half, input int gap,
                           input bit chg_cfg, input bit junk,
                           input int t_inf, input int t_idx, input string tag);
        int t = 0;
        longint held;
        for (int i = 0; i < Q; i++) vec[i] = gen(pat, a, b, c, i);
        model(delta, half);
        cfg_delta = DELTA_W'(delta);
        cfg_half  = HALF_W'(half);
        for (int i = 0; i < Q; i++) begin
            @(negedge clk);
            if (gap > 0 && (i % 7) == 3) begin
                in_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
            while (!in_ready) @(negedge clk);
            if (chg_cfg && i == 1) begin
                cfg_delta = '0;
                cfg_half  = '1;
            end
            in_valid  = 1'b1;
            in_sample = vec[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (junk) begin
            check(in_ready == 1'b0, "R2", "in_ready after last sample", longint'(in_ready), 0);
            for (int j = 0; j < 4; j++) begin
                in_valid  = 1'b1;
                in_sample = 16'h8000;
                @(negedge clk);
            end
            in_valid = 1'b0;
        end
        while (!result_valid && t < 30000) begin
            @(negedge clk);
            t++;
        end
        check(result_valid == 1'b1, "R9", "result arrival", longint'(result_valid), 1);
        check(longint'(threshold) == exp_thr, "R5", "threshold", longint'(threshold), exp_thr);
        check(longint'(infected) == exp_inf, "R7", "infected vs model", longint'(infected), exp_inf);
        check(longint'(peak_idx) == exp_idx, "R8", "peak_idx vs model", longint'(peak_idx), exp_idx);
        if (t_inf >= 0)
            check(longint'(infected) == longint'(t_inf), tag, "infected vs table", longint'(infected), t_inf);
        if (t_idx >= 0)
            check(longint'(peak_idx) == longint'(t_idx), tag, "peak_idx vs table", longint'(peak_idx), t_idx);
        check(in_ready == 1'b1, "R9", "in_ready with result", longint'(in_ready), 1);
        held = longint'(threshold);
        @(negedge clk);
        check(result_valid == 1'b0, "R9", "pulse width", longint'(result_valid), 0);
        repeat (5) @(negedge clk);
        check(longint'(threshold) == held, "R9", "threshold held", longint'(threshold), held);
    endtask

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_sample = '0;
        cfg_delta = '0;
        cfg_half  = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1", "in_ready", longint'(in_ready), 1);
        check(result_valid == 1'b0, "R1", "result_valid", longint'(result_valid), 0);
        check(infected == 1'b0, "R1", "infected", longint'(infected), 0);
        check(threshold == '0, "R1", "threshold", longint'(threshold), 0);
        check(peak_idx == '0, "R1", "peak_idx", longint'(peak_idx), 0);

        for (int n = 0; n < NCASE; n++)
            run_vec(CASES[n].pat, CASES[n].a, CASES[n].b, CASES[n].c, CASES[n].delta,
                    CASES[n].half, n % 2, 1'b0, n == 2, CASES[n].exp_inf, CASES[n].exp_idx, "R7");

        // R3: most negative code taken as magnitude 32768
        run_vec(1, 40, -32768, 0, 1024, 3, 0, 1'b0, 1'b0, 1, 0, "R3");
        // R4: configuration changed after first sample must be ignored
        run_vec(1, 256, 2560, 17, 1024, 0, 0, 1'b1, 1'b0, 1, 17, "R4");
        // R6: window covering the whole vector leaves no candidate
        run_vec(0, 50, 0, 0, 1024, 59, 0, 1'b0, 1'b0, 0, 0, "R6");
        check(threshold == {TH_W{1'b1}}, "R6", "saturated threshold",
              longint'(threshold), (longint'(1) << TH_W) - 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule